// File: doc/BRIEF.md
# Tree-Reduced Keyed Record Store

A small associative store of eight keyed records, each held in its own leaf cell with a valid flag. Above the leaves sits a binary tree of combining nodes. Each lookup sends its key to every leaf at once. The nodes then fold the per-leaf results toward the root, one tree level per clock. At every node, a match lookup keeps the side that matched, a minimum query keeps the smaller key and a maximum query keeps the larger key. The folding is registered at every level, so a new lookup can enter on each cycle while older lookups are still climbing the tree.

Insertion has no scan step. Each internal node holds a count of the empty leaves below it. A new record follows these counts from the root down to a free leaf in the same cycle that the command is accepted. A deletion clears its leaf at once. It then walks back up the freed leaf's path, one level per cycle, and adds one to each counter on the way. While that walk runs, the command port refuses new work. Every command returns exactly one response, in order, a fixed number of cycles after it is accepted.

Top module: `dict_tree`

## Requirements
- R1: A search (opcode 0) returns found=1 with the stored key and data when the key is present, and found=0 otherwise. Its response appears exactly log2(N_LEAF) cycles (3 by default) after the command is accepted.
- R2: An insert (opcode 1) of a key that is absent, into a store that is not full, stores the record and returns found=0, err=0. Later searches find the record.
- R3: An insert of a key already present replaces that record's data, uses no new slot, and returns found=1 with the new data. No two valid leaves ever hold the same key.
- R4: An insert of an absent key into a full store returns err=1 and found=0 and leaves the store unchanged. A response with err=1 never has found=1.
- R5: An insert of an absent key succeeds whenever fewer than N_LEAF records are held, including after deletions have freed arbitrary slots. When no deletion walk is running, the root vacancy count equals the number of empty leaves.
- R6: A delete (opcode 2) of a present key removes the record and returns found=1 with the old data. cmd_ready_o is then low for exactly log2(N_LEAF) cycles.
- R7: A delete of an absent key returns found=0, changes nothing, and leaves cmd_ready_o high.
- R8: findmin (opcode 3) returns the smallest valid key with its data, and findmax (opcode 4) returns the largest. Empty leaves take no part, and on an empty store both return found=0.
- R9: Commands may be accepted on consecutive cycles. Their responses come back in order, one per cycle. Each response reflects the store after all earlier commands and before any later one.
- R10: Opcodes 5, 6 and 7 return found=0 and err=0 and change nothing.
- R11: After reset, the store is empty, cmd_ready_o is 1 and rsp_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken; low during a deletion walk |
| cmd_op_i | input | 3 | 0 search, 1 insert, 2 delete, 3 findmin, 4 findmax |
| cmd_key_i | input | KEY_W | Command key |
| cmd_data_i | input | DATA_W | Data for insert |
| rsp_valid_o | output | 1 | Response present for one cycle |
| rsp_found_o | output | 1 | Key found, record updated, or min/max present |
| rsp_err_o | output | 1 | Insert rejected because the store is full |
| rsp_key_o | output | KEY_W | Key of the response |
| rsp_data_o | output | DATA_W | Data of the response |

## Verification
Two functions can fall in the same cycle. A write (an insert or a delete) changes a leaf on the same edge that a following lookup captures the leaves, and earlier lookups are still climbing the tree at that time. The bench provokes this by issuing commands on consecutive cycles: an insert immediately followed by a search for the same key, a delete followed by a search, and long search sweeps over all 256 keys right after store changes. A shadow dictionary in the bench, updated in command order, supplies every expected response. The bench also checks that each response arrives exactly three cycles after its acceptance.

// File: rtl/dict_pkg.sv
package dict_pkg;
  typedef enum logic [2:0] {
    OP_SEARCH = 3'd0,
    OP_INSERT = 3'd1,
    OP_DELETE = 3'd2,
    OP_MIN    = 3'd3,
    OP_MAX    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RED_MATCH = 2'd0,
    RED_MIN   = 2'd1,
    RED_MAX   = 2'd2
  } red_e;
endpackage

// File: rtl/dict_combine_node.sv
module dict_combine_node
  import dict_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8
) (
  input  red_e              mode_i,
  input  logic              l_hit_i,
  input  logic [KEY_W-1:0]  l_key_i,
  input  logic [DATA_W-1:0] l_data_i,
  input  logic              r_hit_i,
  input  logic [KEY_W-1:0]  r_key_i,
  input  logic [DATA_W-1:0] r_data_i,
  output logic              hit_o,
  output logic [KEY_W-1:0]  key_o,
  output logic [DATA_W-1:0] data_o
);
  logic take_r;

  always_comb begin
    if (l_hit_i && r_hit_i) begin
      unique case (mode_i)
        RED_MIN: take_r = r_key_i < l_key_i;
        RED_MAX: take_r = r_key_i > l_key_i;
        default: take_r = 1'b0;  // match: left side wins
      endcase
    end else begin
      take_r = r_hit_i;
    end
  end

  assign hit_o  = l_hit_i | r_hit_i;
  assign key_o  = take_r ? r_key_i : l_key_i;
  assign data_o = take_r ? r_data_i : l_data_i;
endmodule

// File: rtl/dict_reduce_pipe.sv
module dict_reduce_pipe
  import dict_pkg::*;
#(
  parameter int N_LEAF = 8,
  parameter int LEVELS = 3,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8,
  parameter int SIDE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  red_e              mode_i,
  input  logic [N_LEAF-1:0] leaf_hit_i,
  input  logic [KEY_W-1:0]  leaf_key_i  [N_LEAF],
  input  logic [DATA_W-1:0] leaf_data_i [N_LEAF],
  input  logic [SIDE_W-1:0] side_i,
  output logic              out_valid_o,
  output logic              out_hit_o,
  output logic [KEY_W-1:0]  out_key_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [SIDE_W-1:0] out_side_o
);
  localparam int NODES = 2 * N_LEAF - 1;

  // heap layout: node n stored at index n-1, leaves are nodes N_LEAF..2*N_LEAF-1
  logic              hit_q  [NODES];
  logic [KEY_W-1:0]  key_q  [NODES];
  logic [DATA_W-1:0] data_q [NODES];
  logic              c_hit  [N_LEAF-1];
  logic [KEY_W-1:0]  c_key  [N_LEAF-1];
  logic [DATA_W-1:0] c_data [N_LEAF-1];

  logic              v_q    [LEVELS+1];
  logic [SIDE_W-1:0] side_q [LEVELS+1];
  red_e              mode_q [LEVELS];

  for (genvar n = 1; n < N_LEAF; n++) begin : g_node
    localparam int D = $clog2(n + 1) - 1;
    localparam int S = LEVELS - D - 1;  // stage holding this node's children
    dict_combine_node #(.KEY_W(KEY_W), .DATA_W(DATA_W)) i_node (
      .mode_i  (mode_q[S]),
      .l_hit_i (hit_q[2*n-1]),
      .l_key_i (key_q[2*n-1]),
      .l_data_i(data_q[2*n-1]),
      .r_hit_i (hit_q[2*n]),
      .r_key_i (key_q[2*n]),
      .r_data_i(data_q[2*n]),
      .hit_o   (c_hit[n-1]),
      .key_o   (c_key[n-1]),
      .data_o  (c_data[n-1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NODES; i++) begin
        hit_q[i]  <= 1'b0;
        key_q[i]  <= '0;
        data_q[i] <= '0;
      end
      for (int s = 0; s <= LEVELS; s++) begin
        v_q[s]    <= 1'b0;
        side_q[s] <= '0;
      end
      for (int s = 0; s < LEVELS; s++) mode_q[s] <= RED_MATCH;
    end else begin
      v_q[0]    <= in_valid_i;
      side_q[0] <= side_i;
      mode_q[0] <= mode_i;
      for (int s = 1; s <= LEVELS; s++) begin
        v_q[s]    <= v_q[s-1];
        side_q[s] <= side_q[s-1];
      end
      for (int s = 1; s < LEVELS; s++) mode_q[s] <= mode_q[s-1];
      for (int i = 0; i < N_LEAF; i++) begin
        hit_q[N_LEAF-1+i]  <= leaf_hit_i[i];
        key_q[N_LEAF-1+i]  <= leaf_key_i[i];
        data_q[N_LEAF-1+i] <= leaf_data_i[i];
      end
      for (int i = 0; i < N_LEAF - 1; i++) begin
        hit_q[i]  <= c_hit[i];
        key_q[i]  <= c_key[i];
        data_q[i] <= c_data[i];
      end
    end
  end

  assign out_valid_o = v_q[LEVELS];
  assign out_side_o  = side_q[LEVELS];
  assign out_hit_o   = hit_q[0];
  assign out_key_o   = key_q[0];
  assign out_data_o  = data_q[0];
endmodule

// File: rtl/dict_vacancy.sv
module dict_vacancy #(
  parameter int N_LEAF = 8,
  parameter int LEVELS = 3,
  localparam int CNT_W = LEVELS + 1,
  localparam int IDX_W = LEVELS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LEAF-1:0] leaf_valid_i,
  input  logic              ins_i,
  input  logic              del_i,
  input  logic [IDX_W-1:0]  del_idx_i,
  output logic [IDX_W-1:0]  ins_idx_o,
  output logic [CNT_W-1:0]  root_vac_o,
  output logic              busy_o
);
  logic [CNT_W-1:0] vac_q [N_LEAF-1];  // node n at index n-1
  logic             busy_q;
  logic [IDX_W-1:0] step_q;
  logic [IDX_W-1:0] idx_q;

  // descend from the root, left side first when it has room
  always_comb begin
    int  n;
    logic left_free;
    n = 1;
    left_free = 1'b0;
    for (int d = 0; d < LEVELS; d++) begin
      if (d == LEVELS - 1) left_free = !leaf_valid_i[2*n-N_LEAF];
      else                 left_free = vac_q[2*n-1] != '0;
      n = left_free ? 2 * n : 2 * n + 1;
    end
    ins_idx_o = IDX_W'(n - N_LEAF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < LEVELS; d++)
        for (int j = 0; j < (1 << d); j++)
          vac_q[(1<<d)+j-1] <= CNT_W'(N_LEAF >> d);
      busy_q <= 1'b0;
      step_q <= '0;
      idx_q  <= '0;
    end else begin
      for (int d = 0; d < LEVELS; d++) begin
        for (int j = 0; j < (1 << d); j++) begin
          if (ins_i && ((N_LEAF + int'(ins_idx_o)) >> (LEVELS - d)) == (1 << d) + j)
            vac_q[(1<<d)+j-1] <= vac_q[(1<<d)+j-1] - 1'b1;
          else if (busy_q && d == int'(step_q) &&
                   ((N_LEAF + int'(idx_q)) >> (LEVELS - d)) == (1 << d) + j)
            vac_q[(1<<d)+j-1] <= vac_q[(1<<d)+j-1] + 1'b1;
        end
      end
      // freeing walk climbs one level per cycle
      if (del_i) begin
        busy_q <= 1'b1;
        step_q <= IDX_W'(LEVELS - 1);
        idx_q  <= del_idx_i;
      end else if (busy_q) begin
        if (step_q == '0) busy_q <= 1'b0;
        else              step_q <= step_q - 1'b1;
      end
    end
  end

  assign root_vac_o = vac_q[0];
  assign busy_o     = busy_q;
endmodule

// File: rtl/dict_tree.sv
module dict_tree
  import dict_pkg::*;
#(
  parameter int N_LEAF = 8,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8,
  localparam int LEVELS = $clog2(N_LEAF),
  localparam int IDX_W  = LEVELS,
  localparam int CNT_W  = LEVELS + 1,
  localparam int SIDE_W = 3 + KEY_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [KEY_W-1:0]  cmd_key_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_found_o,
  output logic              rsp_err_o,
  output logic [KEY_W-1:0]  rsp_key_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [N_LEAF-1:0] leaf_valid_q;
  logic [KEY_W-1:0]  leaf_key_q  [N_LEAF];
  logic [DATA_W-1:0] leaf_data_q [N_LEAF];

  logic              accept, busy, any_match;
  logic [N_LEAF-1:0] match, leaf_hit;
  logic [IDX_W-1:0]  match_idx, ins_idx;
  logic [CNT_W-1:0]  root_vac;
  logic              is_ins, ins_new, ins_full, ins_upd, del_hit, tree_op, imm_found;
  logic [DATA_W-1:0] imm_data;
  red_e              red_mode;

  logic [SIDE_W-1:0] side_in, side_out;
  logic              t_hit;
  logic [KEY_W-1:0]  t_key;
  logic [DATA_W-1:0] t_data;

  assign cmd_ready_o = !busy;
  assign accept      = cmd_valid_i && cmd_ready_o;

  always_comb begin
    any_match = 1'b0;
    match_idx = '0;
    for (int i = N_LEAF - 1; i >= 0; i--) begin
      match[i]    = leaf_valid_q[i] && leaf_key_q[i] == cmd_key_i;
      leaf_hit[i] = leaf_valid_q[i] &&
                    (cmd_op_i == OP_MIN || cmd_op_i == OP_MAX ||
                     (cmd_op_i == OP_SEARCH && leaf_key_q[i] == cmd_key_i));
      if (match[i]) begin
        any_match = 1'b1;
        match_idx = IDX_W'(i);
      end
    end
  end

  assign is_ins   = accept && cmd_op_i == OP_INSERT;
  assign ins_upd  = is_ins && any_match;
  assign ins_new  = is_ins && !any_match && root_vac != '0;
  assign ins_full = is_ins && !any_match && root_vac == '0;
  assign del_hit  = accept && cmd_op_i == OP_DELETE && any_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leaf_valid_q <= '0;
      for (int i = 0; i < N_LEAF; i++) begin
        leaf_key_q[i]  <= '0;
        leaf_data_q[i] <= '0;
      end
    end else begin
      if (ins_upd) leaf_data_q[match_idx] <= cmd_data_i;
      if (ins_new) begin
        leaf_valid_q[ins_idx] <= 1'b1;
        leaf_key_q[ins_idx]   <= cmd_key_i;
        leaf_data_q[ins_idx]  <= cmd_data_i;
      end
      if (del_hit) leaf_valid_q[match_idx] <= 1'b0;
    end
  end

  dict_vacancy #(.N_LEAF(N_LEAF), .LEVELS(LEVELS)) i_vac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .leaf_valid_i(leaf_valid_q),
    .ins_i       (ins_new),
    .del_i       (del_hit),
    .del_idx_i   (match_idx),
    .ins_idx_o   (ins_idx),
    .root_vac_o  (root_vac),
    .busy_o      (busy)
  );

  always_comb begin
    unique case (cmd_op_i)
      OP_MIN:  red_mode = RED_MIN;
      OP_MAX:  red_mode = RED_MAX;
      default: red_mode = RED_MATCH;
    endcase
  end

  assign tree_op   = cmd_op_i == OP_SEARCH || cmd_op_i == OP_MIN || cmd_op_i == OP_MAX;
  assign imm_found = any_match && (cmd_op_i == OP_INSERT || cmd_op_i == OP_DELETE);
  assign imm_data  = (cmd_op_i == OP_DELETE) ? leaf_data_q[match_idx] : cmd_data_i;
  assign side_in   = {tree_op, imm_found, ins_full, cmd_key_i, imm_data};

  dict_reduce_pipe #(
    .N_LEAF(N_LEAF), .LEVELS(LEVELS), .KEY_W(KEY_W), .DATA_W(DATA_W), .SIDE_W(SIDE_W)
  ) i_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (accept),
    .mode_i     (red_mode),
    .leaf_hit_i (leaf_hit),
    .leaf_key_i (leaf_key_q),
    .leaf_data_i(leaf_data_q),
    .side_i     (side_in),
    .out_valid_o(rsp_valid_o),
    .out_hit_o  (t_hit),
    .out_key_o  (t_key),
    .out_data_o (t_data),
    .out_side_o (side_out)
  );

  always_comb begin
    if (side_out[SIDE_W-1]) begin
      rsp_found_o = t_hit;
      rsp_err_o   = 1'b0;
      rsp_key_o   = t_key;
      rsp_data_o  = t_data;
    end else begin
      rsp_found_o = side_out[SIDE_W-2];
      rsp_err_o   = side_out[SIDE_W-3];
      rsp_key_o   = side_out[KEY_W+DATA_W-1:DATA_W];
      rsp_data_o  = side_out[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/dict_tree_chk.sv
module dict_tree_chk #(
  parameter int N_LEAF = 8,
  parameter int KEY_W  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [2:0]        cmd_op_i,
  input logic              rsp_valid_o,
  input logic              rsp_found_o,
  input logic              rsp_err_o,
  input logic [N_LEAF-1:0] leaf_valid_q,
  input logic [KEY_W-1:0]  leaf_key_q [N_LEAF],
  input logic              any_match,
  input logic              busy,
  input logic [CNT_W-1:0]  root_vac
);
  logic acc, dup;
  assign acc = cmd_valid_i && cmd_ready_o;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N_LEAF; i++)
      for (int j = i + 1; j < N_LEAF; j++)
        if (leaf_valid_q[i] && leaf_valid_q[j] && leaf_key_q[i] == leaf_key_q[j]) dup = 1'b1;
  end

  a_r3_unique_keys: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);

  a_r4_full_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd1 && !any_match && root_vac == '0) |=> $stable(leaf_valid_q));

  a_r4_err_not_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && !rsp_found_o));

  a_r5_vacancy_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> root_vac == CNT_W'($countones(~leaf_valid_q)));

  a_r6_walk_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd2 && any_match) |=> !cmd_ready_o);

  a_r7_absent_delete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd2 && !any_match) |=> (cmd_ready_o && $stable(leaf_valid_q)));
endmodule

bind dict_tree dict_tree_chk #(.N_LEAF(N_LEAF), .KEY_W(KEY_W), .CNT_W(CNT_W)) i_dict_tree_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_found_o (rsp_found_o),
  .rsp_err_o   (rsp_err_o),
  .leaf_valid_q(leaf_valid_q),
  .leaf_key_q  (leaf_key_q),
  .any_match   (any_match),
  .busy        (busy),
  .root_vac    (root_vac)
);

// File: tb/test_dict_tree.sv
`timescale 1ns/1ps
module test_dict_tree;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_key = '0, cmd_data = '0;
  logic       rsp_valid, rsp_found, rsp_err;
  logic [7:0] rsp_key, rsp_data;

  always #2.5 clk = ~clk;

  dict_tree i_dict_tree (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_key_i(cmd_key), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_found_o(rsp_found), .rsp_err_o(rsp_err),
    .rsp_key_o(rsp_key), .rsp_data_o(rsp_data)
  );

  typedef struct {
    logic       found;
    logic       err;
    logic [7:0] key;
    logic [7:0] data;
    int         acc;
    string      req;
  } exp_t;

  exp_t expq[$];
  int   n_cmp = 0, n_bad = 0, cyc = 0;
  bit   done = 0;

  logic       mv [8];
  logic [7:0] mk [8];
  logic [7:0] md [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // shadow dictionary, updated in command order
  task automatic send(input logic [2:0] op, input logic [7:0] key, input logic [7:0] data);
    exp_t e;
    int   hit, fr, cnt, best;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_data = data;
    while (!cmd_ready) @(negedge clk);
    e.acc = cyc + 1; e.found = 0; e.err = 0; e.key = key; e.data = data;
    hit = -1; fr = -1; cnt = 0; best = -1;
    for (int i = 0; i < 8; i++) begin
      if (mv[i] && mk[i] == key) hit = i;
      if (!mv[i] && fr < 0) fr = i;
      if (mv[i]) cnt++;
    end
    case (op)
      3'd0: begin e.req = "R1"; if (hit >= 0) begin e.found = 1; e.data = md[hit]; end end
      3'd1: begin
        if (hit >= 0) begin e.req = "R3"; e.found = 1; md[hit] = data; end
        else if (cnt == 8) begin e.req = "R4"; e.err = 1; end
        else begin e.req = "R2"; mv[fr] = 1; mk[fr] = key; md[fr] = data; end
      end
      3'd2: begin
        if (hit >= 0) begin e.req = "R6"; e.found = 1; e.data = md[hit]; mv[hit] = 0; end
        else e.req = "R7";
      end
      3'd3, 3'd4: begin
        e.req = "R8";
        for (int i = 0; i < 8; i++)
          if (mv[i] && (best < 0 || (op == 3'd3 ? mk[i] < mk[best] : mk[i] > mk[best]))) best = i;
        if (best >= 0) begin e.found = 1; e.key = mk[best]; e.data = md[best]; end
      end
      default: e.req = "R10";
    endcase
    expq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        chk("R9", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk("R9", "response latency", cyc - e.acc, LAT);
        chk(e.req, "found", rsp_found, e.found);
        chk(e.req, "err", rsp_err, e.err);
        if (e.found) begin
          chk(e.req, "key", rsp_key, e.key);
          chk(e.req, "data", rsp_data, e.data);
        end
      end
    end
  end

  task automatic sweep();
    for (int k = 0; k < 256; k++) send(3'd0, 8'(k), 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mk[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R11", "ready in reset", cmd_ready, 1);
    chk("R11", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", cmd_ready, 1);

    // empty store
    send(3'd3, 8'h00, 8'h00);
    send(3'd4, 8'h00, 8'h00);
    send(3'd0, 8'h05, 8'h00);
    send(3'd2, 8'h05, 8'h00);
    idle();
    chk("R7", "ready after absent delete", cmd_ready, 1);

    // fill, then one over
    for (int i = 0; i < 8; i++) send(3'd1, 8'((i * 37 + 11) & 255), 8'(i * 3 + 1));
    send(3'd1, 8'hF0, 8'h55);
    send(3'd3, 8'h00, 8'h00);
    send(3'd4, 8'h00, 8'h00);
    sweep();

    // overwrite while full, then read back at once
    send(3'd1, 8'd48, 8'hAA);
    send(3'd0, 8'd48, 8'h00);
    send(3'd1, 8'd11, 8'hBB);
    send(3'd3, 8'h00, 8'h00);

    // delete with ready window check
    send(3'd2, 8'd85, 8'h00);
    idle();
    chk("R6", "ready low 1", cmd_ready, 0);
    @(negedge clk); chk("R6", "ready low 2", cmd_ready, 0);
    @(negedge clk); chk("R6", "ready low 3", cmd_ready, 0);
    @(negedge clk); chk("R6", "ready back", cmd_ready, 1);
    send(3'd2, 8'd11, 8'h00);
    send(3'd0, 8'd11, 8'h00);
    send(3'd2, 8'd233, 8'h00);
    send(3'd2, 8'd233, 8'h00);
    send(3'd3, 8'h00, 8'h00);
    send(3'd4, 8'h00, 8'h00);

    // refill freed slots, insert then search next cycle
    send(3'd1, 8'd200, 8'h21);
    send(3'd0, 8'd200, 8'h00);
    send(3'd1, 8'd1, 8'h22);
    send(3'd1, 8'd255, 8'h23);
    send(3'd1, 8'd77, 8'h24);
    send(3'd3, 8'h00, 8'h00);
    send(3'd4, 8'h00, 8'h00);
    sweep();

    // undefined opcodes
    send(3'd5, 8'd200, 8'h01);
    send(3'd6, 8'd1, 8'h02);
    send(3'd7, 8'd9, 8'h03);
    sweep();

    // empty the store
    for (int i = 0; i < 8; i++) if (mv[i]) send(3'd2, mk[i], 8'h00);
    send(3'd3, 8'h00, 8'h00);
    send(3'd4, 8'h00, 8'h00);
    send(3'd1, 8'd9, 8'h99);
    send(3'd3, 8'h00, 8'h00);
    idle();
    repeat (LAT + 3) @(negedge clk);
    chk("R9", "responses outstanding", expq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished (cycle %0d)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule